// File: doc/BRIEF.md
# Fractional-Increment Nanosecond Time Counter

This block keeps a free-running time-of-day value for packet timestamping. A 96-bit accumulator holds 64 bits of whole nanoseconds and 32 bits of nanosecond fraction. While counting is switched on, a programmable step is added to the accumulator on every core clock cycle. The step is a 32.32 fixed-point nanosecond quantity. Its nominal value is (10^9 · 2^32) divided by the core clock rate in Hz. For a 50 MHz clock that is exactly 20 ns with a zero fraction.

Software trims the frequency by rewriting the step at run time. This does not disturb the running time. Software can also load either time word directly. A small strobe-based register port gives access to the control bit, the step and both time words. Reads return after one registered cycle. The current time is also driven out on two ports, for capture logic elsewhere on the chip.

Top module: `ns_time_accum`

## Requirements
- R1: Reset (synchronous, active high) clears the run bit, the step and both time words to zero, and drives zero on the read-data port.
- R2: While the run bit is set and no time word is written, each clock edge adds the 64-bit step to the 96-bit accumulator. Step bits 63:32 are whole nanoseconds and bits 31:0 are fraction. A carry out of the fraction reaches the nanosecond word in the same cycle.
- R3: The nanosecond word wraps modulo 2^64.
- R4: While the run bit is clear, both time words hold their values.
- R5: The control register is at offset 0xF00. Write-data bit 0 sets the run bit, and all other written bits are ignored. A read returns the run bit in bit 0 and zero in all other bits.
- R6: Offset 0xF08 holds the fraction word (data bits 31:0, upper read bits zero). Offset 0xF10 holds the nanosecond word. Offset 0xF18 holds the step. All three can be written and read back.
- R7: A step write is used from the next clock edge on. The edge that captures the write still adds the old step, and the time is not reset.
- R8: A write to a time word loads that word, and no increment is applied to either word on that edge. The word that is not written keeps its value.
- R9: A read strobe captures the addressed register's value from before that edge's update. The value appears on the read-data port one cycle later and stays there until the next read strobe.
- R10: A read at any offset other than the four listed returns zero.
- R11: The time outputs show the current nanosecond and fraction words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 12 | Register byte offset |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Registered read data |
| time_ns | output | 64 | Current whole-nanosecond count |
| time_frac | output | 32 | Current nanosecond fraction |

## Verification
The bench builds the block with its default widths: a 64-bit nanosecond word, a 32-bit fraction and a 12-bit offset bus. These are the widths software sees. Because both time words can be written directly, the bench preloads values just below the 2^64 and fraction-carry boundaries. This makes the wrap and carry cases reachable within a few cycles. With full-width steps, a step of all ones and a step that is only fraction can both be exercised against an exact 96-bit model kept in the bench.

// File: rtl/tacc_pkg.sv
package tacc_pkg;
  // Register offsets that software relies on
  localparam logic [11:0] OFS_CTRL = 12'hF00;
  localparam logic [11:0] OFS_FRAC = 12'hF08;
  localparam logic [11:0] OFS_NSEC = 12'hF10;
  localparam logic [11:0] OFS_STEP = 12'hF18;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_FRAC,
    SEL_NSEC,
    SEL_STEP
  } reg_sel_e;
endpackage

// File: rtl/tacc_decode.sv
module tacc_decode
  import tacc_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);
  always_comb begin
    if (addr == ADDR_W'(OFS_CTRL))      sel = SEL_CTRL;
    else if (addr == ADDR_W'(OFS_FRAC)) sel = SEL_FRAC;
    else if (addr == ADDR_W'(OFS_NSEC)) sel = SEL_NSEC;
    else if (addr == ADDR_W'(OFS_STEP)) sel = SEL_STEP;
    else                                sel = SEL_NONE;
  end
endmodule

// File: rtl/tacc_accum.sv
module tacc_accum #(
  parameter int NS_W   = 64,
  parameter int FRAC_W = 32,
  parameter int STEP_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [STEP_W-1:0] step,
  input  logic              ld_ns,
  input  logic              ld_frac,
  input  logic [NS_W-1:0]   ld_ns_val,
  input  logic [FRAC_W-1:0] ld_frac_val,
  output logic [NS_W-1:0]   ns,
  output logic [FRAC_W-1:0] frac
);
  localparam int ACC_W = NS_W + FRAC_W;

  logic [ACC_W-1:0] acc_next;

  // One wide adder: fraction carry ripples into nanoseconds in-cycle
  assign acc_next = {ns, frac} + ACC_W'(step);

  always_ff @(posedge clk) begin
    if (rst) begin
      ns   <= '0;
      frac <= '0;
    end else if (ld_ns || ld_frac) begin
      if (ld_ns)   ns   <= ld_ns_val;
      if (ld_frac) frac <= ld_frac_val;
    end else if (run) begin
      ns   <= acc_next[ACC_W-1:FRAC_W];
      frac <= acc_next[FRAC_W-1:0];
    end
  end
endmodule

// File: rtl/tacc_ctrl.sv
module tacc_ctrl
  import tacc_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int NS_W   = 64,
  parameter int FRAC_W = 32,
  parameter int STEP_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              rd,
  input  reg_sel_e          sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NS_W-1:0]   ns,
  input  logic [FRAC_W-1:0] frac,
  output logic              run,
  output logic [STEP_W-1:0] step,
  output logic              ld_ns,
  output logic              ld_frac,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] rd_mux;

  assign ld_ns   = wr && (sel == SEL_NSEC);
  assign ld_frac = wr && (sel == SEL_FRAC);

  always_ff @(posedge clk) begin
    if (rst) begin
      run  <= 1'b0;
      step <= '0;
    end else if (wr) begin
      if (sel == SEL_CTRL) run  <= wdata[0];
      if (sel == SEL_STEP) step <= wdata[STEP_W-1:0];
    end
  end

  always_comb begin
    case (sel)
      SEL_CTRL: rd_mux = DATA_W'(run);
      SEL_FRAC: rd_mux = DATA_W'(frac);
      SEL_NSEC: rd_mux = DATA_W'(ns);
      SEL_STEP: rd_mux = DATA_W'(step);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= rd_mux;
  end
endmodule

// File: rtl/ns_time_accum.sv
module ns_time_accum
  import tacc_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 64,
  parameter int NS_W       = 64,
  parameter int FRAC_W     = 32,
  parameter int STEP_INT_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NS_W-1:0]   time_ns,
  output logic [FRAC_W-1:0] time_frac
);
  localparam int STEP_W = STEP_INT_W + FRAC_W;

  reg_sel_e          sel;
  logic              run_q;
  logic [STEP_W-1:0] step_q;
  logic              ld_ns, ld_frac;
  logic [NS_W-1:0]   ns_q;
  logic [FRAC_W-1:0] frac_q;

  tacc_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr (bus_addr),
    .sel  (sel)
  );

  tacc_ctrl #(
    .DATA_W(DATA_W), .NS_W(NS_W), .FRAC_W(FRAC_W), .STEP_W(STEP_W)
  ) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .wr      (bus_wr),
    .rd      (bus_rd),
    .sel     (sel),
    .wdata   (bus_wdata),
    .ns      (ns_q),
    .frac    (frac_q),
    .run     (run_q),
    .step    (step_q),
    .ld_ns   (ld_ns),
    .ld_frac (ld_frac),
    .rdata   (bus_rdata)
  );

  tacc_accum #(
    .NS_W(NS_W), .FRAC_W(FRAC_W), .STEP_W(STEP_W)
  ) u_accum (
    .clk         (clk),
    .rst         (rst),
    .run         (run_q),
    .step        (step_q),
    .ld_ns       (ld_ns),
    .ld_frac     (ld_frac),
    .ld_ns_val   (bus_wdata[NS_W-1:0]),
    .ld_frac_val (bus_wdata[FRAC_W-1:0]),
    .ns          (ns_q),
    .frac        (frac_q)
  );

  assign time_ns   = ns_q;
  assign time_frac = frac_q;
endmodule

// File: rtl/tacc_chk.sv
module tacc_chk
  import tacc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 64,
  parameter int NS_W   = 64,
  parameter int FRAC_W = 32,
  parameter int STEP_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              wr,
  input logic              rd,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic              run,
  input logic [STEP_W-1:0] step,
  input logic [NS_W-1:0]   ns,
  input logic [FRAC_W-1:0] frac
);
  localparam int ACC_W = NS_W + FRAC_W;

  logic hit_ns, hit_frac, hit_any;
  assign hit_ns   = wr && (addr == ADDR_W'(OFS_NSEC));
  assign hit_frac = wr && (addr == ADDR_W'(OFS_FRAC));
  assign hit_any  = (addr == ADDR_W'(OFS_CTRL)) || (addr == ADDR_W'(OFS_FRAC)) ||
                    (addr == ADDR_W'(OFS_NSEC)) || (addr == ADDR_W'(OFS_STEP));

  // R2
  advance_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(run) && !$past(hit_ns) && !$past(hit_frac)) |->
      ({ns, frac} == $past({ns, frac}) + ACC_W'($past(step))));

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(run) && !$past(hit_ns) && !$past(hit_frac)) |-> ($stable(ns) && $stable(frac)));

  // R8
  load_wins_chk: assert property (@(posedge clk) disable iff (rst)
    $past(hit_ns) |-> (ns == $past(wdata[NS_W-1:0])));

  // R8
  other_word_holds_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(hit_ns) && !$past(hit_frac)) |-> $stable(frac));

  // R9
  read_latency_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(rd) && $past(addr) == ADDR_W'(OFS_NSEC)) |-> (rdata == DATA_W'($past(ns))));

  // R9
  read_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rd) |-> $stable(rdata));

  // R10
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(rd) && !$past(hit_any)) |-> (rdata == '0));
endmodule

bind ns_time_accum tacc_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NS_W(NS_W), .FRAC_W(FRAC_W),
  .STEP_W(STEP_INT_W + FRAC_W)
) u_tacc_chk (
  .clk   (clk),
  .rst   (rst),
  .wr    (bus_wr),
  .rd    (bus_rd),
  .addr  (bus_addr),
  .wdata (bus_wdata),
  .rdata (bus_rdata),
  .run   (run_q),
  .step  (step_q),
  .ns    (ns_q),
  .frac  (frac_q)
);

// File: tb/test_ns_time_accum.sv
module test_ns_time_accum;
  localparam logic [11:0] A_CTRL = 12'hF00;
  localparam logic [11:0] A_FRAC = 12'hF08;
  localparam logic [11:0] A_NSEC = 12'hF10;
  localparam logic [11:0] A_STEP = 12'hF18;

  localparam int NV = 5;
  localparam logic [63:0] V_STEP [NV] = '{64'h0000_0014_0000_0000, 64'h0000_0008_8000_0000,
                                         64'h0000_0014_0000_0000, 64'h0000_0000_4000_0000,
                                         64'hFFFF_FFFF_FFFF_FFFF};
  localparam logic [63:0] V_NS   [NV] = '{64'd0, 64'd100, 64'hFFFF_FFFF_FFFF_FFF0,
                                         64'd5, 64'd0};
  localparam logic [31:0] V_FRAC [NV] = '{32'h0, 32'h8000_0000, 32'h0,
                                         32'hC000_0000, 32'h0};
  localparam int          V_N    [NV] = '{10, 3, 2, 7, 4};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [63:0] bus_wdata = '0;
  logic [63:0] bus_rdata;
  logic [63:0] time_ns;
  logic [31:0] time_frac;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ns_time_accum i_ns_time_accum (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .time_ns(time_ns), .time_frac(time_frac)
  );

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Callers stand at a negedge; each task returns at the negedge after its capture edge
  task automatic bus_write(input logic [11:0] a, input logic [63:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [63:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] rv, t, f;
    logic [95:0] model;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    check("R1 time_ns", time_ns, 64'd0);
    check("R11 time_frac", {32'd0, time_frac}, 64'd0);
    bus_read(A_CTRL, rv); check("R1 ctrl", rv, 64'd0);
    bus_read(A_STEP, rv); check("R1 step", rv, 64'd0);
    bus_read(A_NSEC, rv); check("R1 nsec", rv, 64'd0);
    bus_read(A_FRAC, rv); check("R1 frac", rv, 64'd0);

    // Vector table: R2 R3 R6
    for (int i = 0; i < NV; i++) begin
      bus_write(A_STEP, V_STEP[i]);
      bus_write(A_FRAC, {32'd0, V_FRAC[i]});
      bus_write(A_NSEC, V_NS[i]);
      bus_write(A_CTRL, 64'd1);
      repeat (V_N[i] - 1) @(negedge clk);
      bus_write(A_CTRL, 64'd0);
      model = {V_NS[i], V_FRAC[i]};
      for (int k = 0; k < V_N[i]; k++) model = model + {32'd0, V_STEP[i]};
      bus_read(A_NSEC, rv); check("R2/R3 nsec", rv, model[95:32]);
      bus_read(A_FRAC, rv); check("R2 frac", rv, {32'd0, model[31:0]});
      check("R11 time_ns", time_ns, model[95:32]);
      bus_read(A_STEP, rv); check("R6 step readback", rv, V_STEP[i]);
    end

    // R4: hold while disabled
    t = time_ns; f = {32'd0, time_frac};
    repeat (5) @(negedge clk);
    check("R4 ns hold", time_ns, t);
    check("R4 frac hold", {32'd0, time_frac}, f);

    // R7: step change on the fly
    bus_write(A_STEP, 64'h0000_0014_0000_0000);
    bus_write(A_FRAC, 64'd0);
    bus_write(A_NSEC, 64'd0);
    bus_write(A_CTRL, 64'd1);
    check("R7 start", time_ns, 64'd0);
    t = time_ns;
    bus_write(A_STEP, 64'h0000_001E_0000_0000);
    check("R7 old step on write edge", time_ns, t + 64'd20);
    @(negedge clk);
    check("R7 new step next edge", time_ns, t + 64'd50);

    // R8: time-word writes win and the other word holds
    bus_write(A_STEP, 64'h0000_001E_4000_0000);
    f = {32'd0, time_frac};
    bus_write(A_NSEC, 64'd1000);
    check("R8 ns loaded", time_ns, 64'd1000);
    check("R8 frac held", {32'd0, time_frac}, f);
    bus_write(A_FRAC, 64'hFFFF_FFFF_1234_5678);
    check("R8 frac loaded", {32'd0, time_frac}, 64'h1234_5678);
    check("R8 ns held", time_ns, 64'd1000);
    @(negedge clk);
    check("R8 resumes", time_ns, 64'd1030);

    // R9: one-cycle read latency, value before the edge, held after
    t = time_ns;
    bus_read(A_NSEC, rv);
    check("R9 read value", rv, t);
    @(negedge clk);
    check("R9 read held", bus_rdata, t);

    // R5: control bit
    bus_read(A_CTRL, rv); check("R5 ctrl reads run", rv, 64'd1);
    bus_write(A_CTRL, 64'hFFFF_FFFF_FFFF_FFFE);
    bus_read(A_CTRL, rv); check("R5 only bit0 used", rv, 64'd0);
    t = time_ns;
    repeat (3) @(negedge clk);
    check("R5 stopped", time_ns, t);
    bus_write(A_CTRL, 64'h3);
    bus_read(A_CTRL, rv); check("R5 upper bits read zero", rv, 64'd1);
    bus_write(A_CTRL, 64'd0);

    // R10: unmapped offsets
    bus_read(12'hF20, rv); check("R10 0xF20", rv, 64'd0);
    bus_read(12'h000, rv); check("R10 0x000", rv, 64'd0);
    bus_read(12'hF04, rv); check("R10 0xF04", rv, 64'd0);

    // R1: reset while running
    bus_write(A_CTRL, 64'd1);
    repeat (3) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check("R1 ns after reset", time_ns, 64'd0);
    check("R1 rdata after reset", bus_rdata, 64'd0);
    @(negedge clk);
    check("R1 stays stopped", time_ns, 64'd0);
    bus_read(A_STEP, rv); check("R1 step after reset", rv, 64'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule